// File: doc/BRIEF.md
# Block-transfer request framer and response builder

This engine sits between the inbound and outbound message buffers of a block-transfer style management interface and a command backend. The host side fills an inbound byte buffer and then raises a start strobe. The engine checks the frame's own length byte against the number of bytes actually received. It answers the interface-capabilities query itself. Every other command goes to the backend as a byte stream tagged with a response identifier.

The sequence byte of a forwarded request is held inside the engine. It is put back into place when the backend reply is turned into an outbound frame. A reply carrying a stale identifier is consumed and thrown away. A reply too large for the outbound buffer is replaced by a short error frame. Each finished reply drops the engine-busy flag, raises the attention flag and gives one response-ready pulse for the interrupt logic.

Top module: `bt_frame_engine`

## Requirements
- R1: After reset, busy and attention are low, no forward byte is offered, the response port is ready, out_avail is low and out_data reads 0xFF.
- R2: A start strobe sets busy. If fewer than 4 bytes have been received, the start does nothing else: nothing is forwarded, busy stays set and the byte count is kept, so bytes added later extend the same frame.
- R3: If byte 0 of the frame is not equal to the received byte count minus one, or the count exceeds IN_DEPTH, the frame is dropped and the received count returns to zero. Busy stays set.
- R4: A frame whose byte 1 is 0x18 and byte 3 is 0x36 is answered locally with the 10-byte frame 9, byte1|0x04, byte 2, byte 3, 0x00, 0x01, min(IN_DEPTH,255), min(OUT_DEPTH,255), 10, 0x00. The response identifier does not change.
- R5: Any other valid frame is forwarded as byte 1, then bytes 3 onward. That is count−2 bytes, with fwd_last on the final byte and fwd_id equal to the current identifier. Data is held while fwd_ready is low. Byte 2 (sequence) is saved.
- R6: A backend reply is used only if rsp_id on its first byte equals the current identifier, which starts at 0 and advances by one per reply used. A reply that does not match is consumed with no effect on outputs.
- R7: A used reply of n bytes with n ≤ OUT_DEPTH−2 yields the frame n+1, reply byte 0, saved sequence, reply bytes 1..n−1. That frame is n+2 bytes long.
- R8: A used reply with n > OUT_DEPTH−2 yields instead the 5-byte frame 4, reply byte 0, saved sequence, reply byte 1, 0xCA.
- R9: When a frame completes, busy is low, attention is high and rsp_done is high for exactly one cycle. attn_clr drops attention on the next cycle.
- R10: out_avail is high while unread outbound bytes remain. out_pop advances the read index. After the last byte out_avail falls and out_data reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_wr | input | 1 | Append in_data to the inbound frame |
| in_data | input | 8 | Inbound byte |
| in_clr | input | 1 | Reset inbound byte count |
| go | input | 1 | Host start strobe |
| attn_clr | input | 1 | Clear the attention flag |
| busy | output | 1 | Engine busy flag |
| attn | output | 1 | Reply-waiting attention flag |
| rsp_done | output | 1 | One-cycle reply-ready pulse |
| fwd_valid | output | 1 | Forward byte valid |
| fwd_ready | input | 1 | Backend accepts forward byte |
| fwd_data | output | 8 | Forward byte |
| fwd_last | output | 1 | Final forward byte |
| fwd_id | output | ID_W | Response identifier of the request |
| rsp_valid | input | 1 | Reply byte valid |
| rsp_ready | output | 1 | Engine accepts reply byte |
| rsp_data | input | 8 | Reply byte |
| rsp_last | input | 1 | Final reply byte |
| rsp_id | input | ID_W | Identifier of the reply, read on its first byte |
| out_pop | input | 1 | Advance outbound read index |
| out_data | output | 8 | Outbound byte at read index |
| out_avail | output | 1 | Unread outbound bytes remain |

## Verification
The assertions assume that the backend starts a reply only while the engine offers rsp_ready without a start strobe in the same cycle. They also assume that the host does not pop the outbound buffer or raise a reply while a frame is being built. The stimulus follows these rules. It drives every reply byte only after forwarding has finished, and it drains each outbound frame before the next reply begins. Stale identifiers are sent only while the engine is idle, so a dropped reply can be told apart from a delayed one at the ports.

// File: rtl/bt_frame_pkg.sv
package bt_frame_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CAPS,
        ST_FWD,
        ST_RX,
        ST_HDR
    } eng_state_e;

    localparam logic [7:0] NETFN_APP_REQ = 8'h18;
    localparam logic [7:0] CMD_CAPS      = 8'h36;
    localparam logic [7:0] NETFN_RSP_BIT = 8'h04;
    localparam logic [7:0] CC_TOO_LONG   = 8'hCA;
    localparam int         CAPS_BYTES    = 10;
    localparam logic [7:0] CAPS_TIME_S   = 8'd10;

    function automatic logic [7:0] sat_byte(input int v);
        return (v > 255) ? 8'hFF : 8'(v);
    endfunction

endpackage

// File: rtl/bt_req_store.sv
module bt_req_store #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             clr,
    output logic [CNT_W-1:0] len,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic [7:0]       hdr0,
    output logic [7:0]       hdr1,
    output logic [7:0]       hdr2,
    output logic [7:0]       hdr3
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic [7:0]       mem_q [DEPTH];
    logic [CNT_W-1:0] len_d, len_q;

    always_comb begin
        len_d = len_q;
        if (clr)
            len_d = '0;
        else if (wr_en && !(&len_q))
            len_d = len_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len_q <= '0;
        else
            len_q <= len_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr && (len_q < CAP))
            mem_q[IDX_W'(len_q)] <= wr_data;
    end

    assign len     = len_q;
    assign rd_data = mem_q[rd_addr];
    assign hdr0    = mem_q[0];
    assign hdr1    = mem_q[1];
    assign hdr2    = mem_q[2];
    assign hdr3    = mem_q[3];

endmodule

// File: rtl/bt_rsp_store.sv
module bt_rsp_store #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             kill,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             pop,
    output logic [7:0]       rd_data,
    output logic             avail
);
    logic [7:0]       mem_q [DEPTH];
    logic [CNT_W-1:0] ptr_d, ptr_q, len_d, len_q;
    logic [CNT_W-1:0] ptr_inc;

    assign avail   = ptr_q < len_q;
    assign ptr_inc = ptr_q + 1'b1;

    always_comb begin
        ptr_d = ptr_q;
        len_d = len_q;
        if (kill) begin
            ptr_d = '0;
            len_d = '0;
        end else if (load) begin
            ptr_d = '0;
            len_d = load_len;
        end else if (pop && avail) begin
            if (ptr_inc == len_q) begin
                ptr_d = '0;
                len_d = '0;
            end else begin
                ptr_d = ptr_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            len_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            len_q <= len_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = avail ? mem_q[IDX_W'(ptr_q)] : 8'hFF;

endmodule

// File: rtl/bt_frame_engine.sv
module bt_frame_engine
    import bt_frame_pkg::*;
#(
    parameter int IN_DEPTH  = 64,
    parameter int OUT_DEPTH = 64,
    parameter int ID_W      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_wr,
    input  logic [7:0]      in_data,
    input  logic            in_clr,
    input  logic            go,
    input  logic            attn_clr,
    output logic            busy,
    output logic            attn,
    output logic            rsp_done,
    output logic            fwd_valid,
    input  logic            fwd_ready,
    output logic [7:0]      fwd_data,
    output logic            fwd_last,
    output logic [ID_W-1:0] fwd_id,
    input  logic            rsp_valid,
    output logic            rsp_ready,
    input  logic [7:0]      rsp_data,
    input  logic            rsp_last,
    input  logic [ID_W-1:0] rsp_id,
    input  logic            out_pop,
    output logic [7:0]      out_data,
    output logic            out_avail
);
    localparam int IIDX_W = $clog2(IN_DEPTH);
    localparam int OIDX_W = $clog2(OUT_DEPTH);
    localparam int MAXD   = (IN_DEPTH > OUT_DEPTH) ? IN_DEPTH : OUT_DEPTH;
    localparam int CNT_W  = $clog2(MAXD + 1) + 1;
    localparam logic [CNT_W-1:0] IN_CAP   = CNT_W'(IN_DEPTH);
    localparam logic [CNT_W-1:0] OVER_LIM = CNT_W'(OUT_DEPTH - 2);
    localparam logic [7:0]       IN_SZ    = sat_byte(IN_DEPTH);
    localparam logic [7:0]       OUT_SZ   = sat_byte(OUT_DEPTH);

    typedef struct packed {
        eng_state_e      st;
        logic            busy;
        logic            attn;
        logic            done;
        logic            match;
        logic [7:0]      seq;
        logic [7:0]      netfn;
        logic [7:0]      cmd;
        logic [ID_W-1:0] id;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] idx;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [CNT_W-1:0]  in_len;
    logic [7:0]        hdr0, hdr1, hdr2, hdr3, rd_byte;
    logic [IIDX_W-1:0] rd_addr;
    logic              drop_req;
    logic              ow_en, kill, load;
    logic [OIDX_W-1:0] ow_addr;
    logic [7:0]        ow_data;
    logic [CNT_W-1:0]  load_len;
    logic              over;
    logic              fwd_end;

    function automatic logic [7:0] caps_byte(input logic [CNT_W-1:0] i,
                                             input logic [7:0] nf,
                                             input logic [7:0] sq,
                                             input logic [7:0] cm);
        case (int'(i))
            0:       return 8'(CAPS_BYTES - 1);
            1:       return nf | NETFN_RSP_BIT;
            2:       return sq;
            3:       return cm;
            4:       return 8'h00;
            5:       return 8'h01;
            6:       return IN_SZ;
            7:       return OUT_SZ;
            8:       return CAPS_TIME_S;
            default: return 8'h00;
        endcase
    endfunction

    bt_req_store #(.DEPTH(IN_DEPTH), .CNT_W(CNT_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_wr),
        .wr_data (in_data),
        .clr     (in_clr | drop_req),
        .len     (in_len),
        .rd_addr (rd_addr),
        .rd_data (rd_byte),
        .hdr0    (hdr0),
        .hdr1    (hdr1),
        .hdr2    (hdr2),
        .hdr3    (hdr3)
    );

    bt_rsp_store #(.DEPTH(OUT_DEPTH), .CNT_W(CNT_W)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ow_en),
        .wr_addr  (ow_addr),
        .wr_data  (ow_data),
        .kill     (kill),
        .load     (load),
        .load_len (load_len),
        .pop      (out_pop),
        .rd_data  (out_data),
        .avail    (out_avail)
    );

    assign over    = eng_q.cnt > OVER_LIM;
    assign fwd_end = eng_q.idx == (in_len - CNT_W'(3));
    assign rd_addr = (eng_q.idx == '0) ? IIDX_W'(1) : IIDX_W'(eng_q.idx + CNT_W'(2));

    always_comb begin
        eng_d     = eng_q;
        eng_d.done = 1'b0;
        drop_req  = 1'b0;
        ow_en     = 1'b0;
        ow_addr   = '0;
        ow_data   = 8'h00;
        kill      = 1'b0;
        load      = 1'b0;
        load_len  = '0;
        fwd_valid = 1'b0;
        fwd_last  = 1'b0;
        rsp_ready = 1'b0;

        if (attn_clr)
            eng_d.attn = 1'b0;

        case (eng_q.st)
            ST_IDLE: begin
                if (go) begin
                    eng_d.busy = 1'b1;
                    eng_d.st   = ST_CHECK;
                end else begin
                    rsp_ready = 1'b1;
                    if (rsp_valid) begin
                        eng_d.netfn = rsp_data;
                        eng_d.match = (rsp_id == eng_q.id);
                        eng_d.cnt   = CNT_W'(1);
                        eng_d.idx   = '0;
                        kill        = (rsp_id == eng_q.id);
                        if (rsp_last)
                            eng_d.st = (rsp_id == eng_q.id) ? ST_HDR : ST_IDLE;
                        else
                            eng_d.st = ST_RX;
                    end
                end
            end

            ST_CHECK: begin
                eng_d.idx = '0;
                if (in_len < CNT_W'(4)) begin
                    eng_d.st = ST_IDLE;
                end else if ((in_len > IN_CAP) || (int'(in_len) != int'(hdr0) + 1)) begin
                    drop_req = 1'b1;
                    eng_d.st = ST_IDLE;
                end else begin
                    eng_d.netfn = hdr1;
                    eng_d.seq   = hdr2;
                    eng_d.cmd   = hdr3;
                    if ((hdr1 == NETFN_APP_REQ) && (hdr3 == CMD_CAPS)) begin
                        kill     = 1'b1;
                        eng_d.st = ST_CAPS;
                    end else begin
                        eng_d.st = ST_FWD;
                    end
                end
            end

            ST_CAPS: begin
                ow_en     = 1'b1;
                ow_addr   = OIDX_W'(eng_q.idx);
                ow_data   = caps_byte(eng_q.idx, eng_q.netfn, eng_q.seq, eng_q.cmd);
                eng_d.idx = eng_q.idx + 1'b1;
                if (int'(eng_q.idx) == CAPS_BYTES - 1) begin
                    load       = 1'b1;
                    load_len   = CNT_W'(CAPS_BYTES);
                    eng_d.busy = 1'b0;
                    eng_d.attn = 1'b1;
                    eng_d.done = 1'b1;
                    eng_d.st   = ST_IDLE;
                end
            end

            ST_FWD: begin
                fwd_valid = 1'b1;
                fwd_last  = fwd_end;
                if (fwd_ready) begin
                    eng_d.idx = eng_q.idx + 1'b1;
                    if (fwd_end)
                        eng_d.st = ST_IDLE;
                end
            end

            ST_RX: begin
                rsp_ready = 1'b1;
                if (rsp_valid) begin
                    if (eng_q.cnt == CNT_W'(1))
                        eng_d.cmd = rsp_data;
                    if (eng_q.match && (eng_q.cnt < OVER_LIM)) begin
                        ow_en   = 1'b1;
                        ow_addr = OIDX_W'(eng_q.cnt + CNT_W'(2));
                        ow_data = rsp_data;
                    end
                    if (!(&eng_q.cnt))
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    if (rsp_last) begin
                        eng_d.idx = '0;
                        eng_d.st  = eng_q.match ? ST_HDR : ST_IDLE;
                    end
                end
            end

            ST_HDR: begin
                ow_en     = 1'b1;
                ow_addr   = OIDX_W'(eng_q.idx);
                eng_d.idx = eng_q.idx + 1'b1;
                case (int'(eng_q.idx))
                    0:       ow_data = over ? 8'd4 : 8'(eng_q.cnt + 1'b1);
                    1:       ow_data = eng_q.netfn;
                    2:       ow_data = eng_q.seq;
                    3:       ow_data = eng_q.cmd;
                    default: ow_data = CC_TOO_LONG;
                endcase
                if (int'(eng_q.idx) == (over ? 4 : 2)) begin
                    load       = 1'b1;
                    load_len   = over ? CNT_W'(5) : (eng_q.cnt + CNT_W'(2));
                    eng_d.id   = eng_q.id + 1'b1;
                    eng_d.busy = 1'b0;
                    eng_d.attn = 1'b1;
                    eng_d.done = 1'b1;
                    eng_d.st   = ST_IDLE;
                end
            end

            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy     = eng_q.busy;
    assign attn     = eng_q.attn;
    assign rsp_done = eng_q.done;
    assign fwd_data = rd_byte;
    assign fwd_id   = eng_q.id;

endmodule

// File: rtl/bt_frame_engine_chk.sv
module bt_frame_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       busy,
    input logic       attn,
    input logic       rsp_done,
    input logic       rsp_valid,
    input logic       fwd_valid,
    input logic       fwd_ready,
    input logic [7:0] fwd_data,
    input logic       fwd_last,
    input logic       out_avail,
    input logic       out_pop
);
    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    // R9
    done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!busy && attn));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R5
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_data) && $stable(fwd_last)));

    // R5
    fwd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> busy);

    // R7
    done_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> out_avail);

    // R10
    avail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_avail && !out_pop && !rsp_valid && !busy) |=> out_avail);

endmodule

bind bt_frame_engine bt_frame_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .busy      (busy),
    .attn      (attn),
    .rsp_done  (rsp_done),
    .rsp_valid (rsp_valid),
    .fwd_valid (fwd_valid),
    .fwd_ready (fwd_ready),
    .fwd_data  (fwd_data),
    .fwd_last  (fwd_last),
    .out_avail (out_avail),
    .out_pop   (out_pop)
);

// File: tb/bt_frame_engine_test.sv
`timescale 1ns/1ps
module bt_frame_engine_test;
    localparam int IN_D  = 300;
    localparam int OUT_D = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_wr = 0, in_clr = 0, go = 0, attn_clr = 0, fwd_ready = 1;
    logic [7:0] in_data = 0, rsp_data = 0;
    logic rsp_valid = 0, rsp_last = 0, out_pop = 0;
    logic [7:0] rsp_id = 0;
    logic busy, attn, rsp_done, fwd_valid, fwd_last, rsp_ready, out_avail;
    logic [7:0] fwd_data, fwd_id, out_data;

    always #2.5 clk = ~clk;

    bt_frame_engine #(.IN_DEPTH(IN_D), .OUT_DEPTH(OUT_D), .ID_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_data(in_data), .in_clr(in_clr),
        .go(go), .attn_clr(attn_clr), .busy(busy), .attn(attn), .rsp_done(rsp_done),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_data(fwd_data),
        .fwd_last(fwd_last), .fwd_id(fwd_id), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_id(rsp_id), .out_pop(out_pop),
        .out_data(out_data), .out_avail(out_avail)
    );

    int checks = 0, errors = 0;
    logic [7:0] fbuf [64];
    logic [7:0] rbuf [64];
    logic [7:0] ebuf [64];
    int fcount, rcount, ecount;
    logic [7:0] fid_seen;
    logic [7:0] exp_id = 0;
    logic done_seen;

    // netfn, seq, cmd, data bytes, reply bytes
    localparam logic [39:0] VECS [4] = '{
        {8'h2C, 8'h11, 8'h01, 8'd0, 8'd3},
        {8'h28, 8'h22, 8'h40, 8'd5, 8'd1},
        {8'h06, 8'h33, 8'h07, 8'd2, 8'd38},
        {8'h30, 8'h44, 8'h09, 8'd1, 8'd39}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); in_wr = 1; in_data = b;
        @(negedge clk); in_wr = 0;
    endtask

    task automatic clr_in;
        @(negedge clk); in_clr = 1;
        @(negedge clk); in_clr = 0;
    endtask

    task automatic pulse_go;
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
    endtask

    task automatic send_req(input logic [7:0] nf, input logic [7:0] sq, input logic [7:0] cm,
                            input int nd);
        push(8'(3 + nd)); push(nf); push(sq); push(cm);
        for (int k = 0; k < nd; k++) push(8'hA0 + 8'(k));
    endtask

    task automatic collect_fwd;
        fcount = 0;
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (fwd_valid) begin
                fbuf[fcount] = fwd_data;
                fid_seen = fwd_id;
                fcount++;
                if (fwd_last) break;
            end
        end
    endtask

    function automatic logic [7:0] rbyte(input logic [7:0] nf, input logic [7:0] cm, input int k);
        if (k == 0) return nf | 8'h04;
        if (k == 1) return cm;
        return 8'h50 + 8'(k);
    endfunction

    task automatic send_rsp(input logic [7:0] nf, input logic [7:0] cm, input int n,
                            input logic [7:0] id);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rsp_valid = 1; rsp_data = rbyte(nf, cm, k); rsp_last = (k == n - 1); rsp_id = id;
        end
        @(negedge clk); rsp_valid = 0; rsp_last = 0;
    endtask

    task automatic wait_done(input int lim);
        done_seen = 0;
        for (int t = 0; t < lim; t++) begin
            @(negedge clk);
            if (rsp_done) begin done_seen = 1; break; end
        end
    endtask

    task automatic read_frame;
        rcount = 0;
        for (int t = 0; t < 64; t++) begin
            @(negedge clk);
            out_pop = 0;
            if (!out_avail) break;
            rbuf[rcount] = out_data;
            rcount++;
            out_pop = 1;
        end
        out_pop = 0;
    endtask

    task automatic cmp_frame(input string tag);
        chk(rcount == ecount, {tag, " frame length"}, rcount, ecount);
        for (int i = 0; i < ecount && i < rcount; i++)
            chk(rbuf[i] == ebuf[i], {tag, " frame byte"}, rbuf[i], ebuf[i]);
        chk(!out_avail && out_data == 8'hFF, "R10 drained read", out_data, 8'hFF);
    endtask

    task automatic cmp_fwd(input logic [7:0] nf, input logic [7:0] cm, input int nd, input string tag);
        chk(fcount == nd + 2, {tag, " forward count"}, fcount, nd + 2);
        if (fcount > 0) chk(fbuf[0] == nf, {tag, " forward netfn"}, fbuf[0], nf);
        if (fcount > 1) chk(fbuf[1] == cm, {tag, " forward cmd"}, fbuf[1], cm);
        for (int k = 0; k < nd && k + 2 < fcount; k++)
            chk(fbuf[k+2] == 8'hA0 + 8'(k), {tag, " forward data"}, fbuf[k+2], 8'hA0 + 8'(k));
        chk(fid_seen == exp_id, "R6 forward id", fid_seen, exp_id);
    endtask

    task automatic expect_rsp(input logic [7:0] nf, input logic [7:0] sq, input logic [7:0] cm,
                              input int n);
        if (n > OUT_D - 2) begin
            ebuf[0] = 8'd4; ebuf[1] = rbyte(nf, cm, 0); ebuf[2] = sq;
            ebuf[3] = rbyte(nf, cm, 1); ebuf[4] = 8'hCA; ecount = 5;
        end else begin
            ebuf[0] = 8'(n + 1); ebuf[1] = rbyte(nf, cm, 0); ebuf[2] = sq;
            for (int k = 1; k < n; k++) ebuf[k+2] = rbyte(nf, cm, k);
            ecount = n + 2;
        end
    endtask

    task automatic finish_rsp(input logic [7:0] nf, input logic [7:0] sq, input logic [7:0] cm,
                              input int n, input string tag);
        send_rsp(nf, cm, n, exp_id);
        wait_done(20);
        chk(done_seen, "R9 response done pulse", done_seen, 1);
        chk(!busy && attn, "R9 busy low attention high", {busy, attn}, 2'b01);
        @(negedge clk);
        chk(!rsp_done, "R9 done lasts one cycle", rsp_done, 0);
        exp_id++;
        expect_rsp(nf, sq, cm, n);
        read_frame;
        cmp_frame(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..all act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !attn && !fwd_valid && rsp_ready, "R1 reset flags",
            {busy, attn, fwd_valid, rsp_ready}, 4'b0001);
        chk(!out_avail && out_data == 8'hFF, "R1 reset outbound", out_data, 8'hFF);
        rst_n = 1;
        @(negedge clk);

        // table-driven forward and reply, R5 R7 R8
        foreach (VECS[v]) begin
            logic [7:0] nf, sq, cm;
            int nd, rn;
            {nf, sq, cm} = VECS[v][39:16];
            nd = int'(VECS[v][15:8]);
            rn = int'(VECS[v][7:0]);
            clr_in;
            send_req(nf, sq, cm, nd);
            pulse_go;
            chk(busy, "R2 go sets busy", busy, 1);
            collect_fwd;
            cmp_fwd(nf, cm, nd, "R5");
            finish_rsp(nf, sq, cm, rn, rn > OUT_D - 2 ? "R8" : "R7");
        end

        // R9 attention clear
        @(negedge clk); attn_clr = 1;
        @(negedge clk); attn_clr = 0;
        chk(!attn, "R9 attn_clr", attn, 0);

        // R4 capabilities reply
        clr_in;
        send_req(8'h18, 8'h5A, 8'h36, 0);
        pulse_go;
        wait_done(30);
        chk(done_seen && !busy && attn, "R4 caps completes", done_seen, 1);
        ebuf[0] = 9; ebuf[1] = 8'h1C; ebuf[2] = 8'h5A; ebuf[3] = 8'h36; ebuf[4] = 0;
        ebuf[5] = 1; ebuf[6] = 8'hFF; ebuf[7] = 8'(OUT_D); ebuf[8] = 10; ebuf[9] = 0;
        ecount = 10;
        read_frame;
        cmp_frame("R4");

        // R2 short request ignored, count kept
        clr_in;
        push(8'd3); push(8'h2C); push(8'h66);
        pulse_go;
        collect_fwd;
        chk(fcount == 0, "R2 short not forwarded", fcount, 0);
        chk(busy, "R2 busy kept", busy, 1);
        push(8'h0B);
        pulse_go;
        collect_fwd;
        cmp_fwd(8'h2C, 8'h0B, 0, "R2");
        finish_rsp(8'h2C, 8'h66, 8'h0B, 2, "R2");

        // R3 mismatched length discarded and count reset
        clr_in;
        push(8'd9); push(8'h2C); push(8'h77); push(8'h0C); push(8'h01);
        pulse_go;
        collect_fwd;
        chk(fcount == 0, "R3 mismatch not forwarded", fcount, 0);
        chk(busy, "R3 busy kept", busy, 1);
        send_req(8'h34, 8'h78, 8'h0D, 1);
        pulse_go;
        collect_fwd;
        cmp_fwd(8'h34, 8'h0D, 1, "R3");
        finish_rsp(8'h34, 8'h78, 8'h0D, 4, "R3");

        // R6 stale identifier dropped, then matching one used
        clr_in;
        send_req(8'h2C, 8'h79, 8'h0E, 0);
        pulse_go;
        collect_fwd;
        cmp_fwd(8'h2C, 8'h0E, 0, "R6");
        send_rsp(8'h2C, 8'h0E, 3, exp_id + 8'd3);
        wait_done(20);
        chk(!done_seen, "R6 stale reply no done", done_seen, 0);
        chk(busy && !out_avail, "R6 stale reply no effect", {busy, out_avail}, 2'b10);
        finish_rsp(8'h2C, 8'h79, 8'h0E, 3, "R6");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule